// File: doc/BRIEF.md
# Programmable Interval Timer with Timeout Flag

This block is a single-shot interval timer that software controls through two byte-wide registers. The interval register holds a count `n` of base ticks. One base tick lasts 0.2 ms, and a prescaler makes it from the system clock. The control register holds an enable bit. When software sets the enable bit where it was clear, the prescaler and the tick counter both start again from zero. After exactly `n` base ticks the block raises a timeout flag.

The flag can be read as bit 7 of a status byte. It also drives an interrupt request, which is gated by an externally supplied interrupt-enable bit. Once the flag is set, the counter stops and the flag stays set. Reading the flag does not clear it. The only way to clear it is to write the enable bit to zero. To get the next timeout, software must set the enable bit again.

Address decoding is limited to the status, interval and control byte offsets. The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `interval_timer`

## Requirements
- R1: After reset the interval register reads 0x01, the control register reads 0x00, the status byte reads 0x00 and `tmr_irq` is low.
- R2: The interval register is at byte offset 3. A write there stores all 8 bits, and a read returns the stored value unchanged, including 0.
- R3: The control register is at byte offset 4, and only bit 0 (enable) is implemented. The other bits read as 0. A write with bit 0 clear leaves the timer idle, and no flag appears.
- R4: A write that changes enable from 0 to 1 makes the flag read high exactly `n * CLKS_PER_TICK` clock cycles after the write edge, and not earlier.
- R5: A stored interval of 0 times out like an interval of 1.
- R6: The status byte is at offset 2. Bit 7 is the timeout flag, and bits 6..0 read 0.
- R7: `tmr_irq` is high exactly when the flag is set and `tmr_irq_en` is high.
- R8: Once the flag is set it stays set, and no further counting happens until enable is written to 0. Writing enable = 1 while the timer is already enabled neither clears the flag nor restarts the count.
- R9: Writing enable = 0 clears the flag on the next edge, and the flag stays clear while the timer is disabled.
- R10: A disable followed by a re-enable in the middle of an interval restarts the whole interval from zero.
- R11: Reads at byte offsets other than 2, 3 and 4 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Byte offset for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| tmr_irq_en | input | 1 | Timer interrupt enable bit from the interrupt-enable register |
| tmr_irq | output | 1 | Timer interrupt request |

## Verification
The assertions assume one thing about the inputs: software does not rewrite the interval register while a count is running. That assumption lets them bound the tick counter by the effective interval. The stimulus respects it by writing the interval only while the timer is disabled or while the flag is pending. Every write lasts one cycle and is driven on the falling clock edge, so each start and each stop pulse lines up with exactly one rising edge.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 8;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_INTERVAL = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 3'd4;
  localparam int STATUS_FLAG_BIT = 7;
  localparam int CTRL_EN_BIT     = 0;
  localparam logic [REG_W-1:0] INTERVAL_RST = 8'h01;
endpackage

// File: rtl/itmr_rst_sync.sv
module itmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              flag,
  output logic              en,
  output logic              start,
  output logic              stop,
  output logic [REG_W-1:0]  n_eff,
  output logic [REG_W-1:0]  rd_data
);
  logic [REG_W-1:0] ival_q, ival_d;
  logic             en_q, en_d;
  logic             wr_ival, wr_ctrl;

  always_comb begin
    wr_ival = wr_en && (addr == OFS_INTERVAL);
    wr_ctrl = wr_en && (addr == OFS_CTRL);
    ival_d  = wr_ival ? wr_data : ival_q;
    en_d    = wr_ctrl ? wr_data[CTRL_EN_BIT] : en_q;
    start   = wr_ctrl &&  wr_data[CTRL_EN_BIT] && !en_q;
    stop    = wr_ctrl && !wr_data[CTRL_EN_BIT];
    n_eff   = (ival_q == '0) ? REG_W'(1) : ival_q;
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      OFS_STATUS:   rd_data[STATUS_FLAG_BIT] = flag;
      OFS_INTERVAL: rd_data = ival_q;
      OFS_CTRL:     rd_data[CTRL_EN_BIT] = en_q;
      default:      rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= INTERVAL_RST;
      en_q   <= 1'b0;
    end else begin
      if (wr_ival) ival_q <= ival_d;
      if (wr_ctrl) en_q   <= en_d;
    end
  end

  assign en = en_q;
endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int CLKS_PER_TICK = 50000,
  localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  output logic          tick,
  output logic [PW-1:0] pcnt
);
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pcnt_ce;

  always_comb begin
    tick    = run && (pcnt_q == LAST);
    pcnt_ce = restart || run;
    if (restart)   pcnt_d = '0;
    else if (tick) pcnt_d = '0;
    else           pcnt_d = pcnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_ce) pcnt_q <= pcnt_d;
  end

  assign pcnt = pcnt_q;
endmodule

// File: rtl/itmr_tick_count.sv
module itmr_tick_count
  import itmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  input  logic [REG_W-1:0] n_eff,
  output logic [REG_W-1:0] cnt,
  output logic             flag
);
  logic [REG_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             ce;

  always_comb begin
    ce     = start || stop || tick;
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (start || stop) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (tick) begin
      cnt_d = cnt_q + REG_W'(1);
      if ({1'b0, cnt_q} + 9'd1 >= {1'b0, n_eff}) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (ce) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int CLKS_PER_TICK = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              tmr_irq_en,
  output logic              tmr_irq
);
  localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;

  logic             rst_s_n;
  logic             en, start, stop, flag, tick, run;
  logic [REG_W-1:0] n_eff, cnt;
  logic [PW-1:0]    pcnt;

  itmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  itmr_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .flag(flag), .en(en), .start(start),
    .stop(stop), .n_eff(n_eff), .rd_data(rd_data)
  );

  assign run = en && !flag && !stop;

  itmr_prescaler #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_pre (
    .clk(clk), .rst_n(rst_s_n), .run(run), .restart(start),
    .tick(tick), .pcnt(pcnt)
  );

  itmr_tick_count u_cnt (
    .clk(clk), .rst_n(rst_s_n), .start(start), .stop(stop),
    .tick(tick), .n_eff(n_eff), .cnt(cnt), .flag(flag)
  );

  assign tmr_irq = flag && tmr_irq_en;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk
  import itmr_pkg::*;
#(
  parameter int CLKS_PER_TICK = 50000,
  localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wr_data,
  input logic              en,
  input logic              start,
  input logic              flag,
  input logic              tick,
  input logic [PW-1:0]     pcnt,
  input logic [REG_W-1:0]  cnt,
  input logic [REG_W-1:0]  n_eff,
  input logic              tmr_irq_en,
  input logic              tmr_irq
);
  logic disable_wr;
  assign disable_wr = wr_en && (addr == OFS_CTRL) && !wr_data[CTRL_EN_BIT];

  p_flag_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    flag |-> en);

  p_flag_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(flag) |-> $past(tick));

  p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flag && !disable_wr) |=> flag);

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    disable_wr |=> (!flag && !en));

  p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    start |=> (en && !flag && pcnt == '0 && cnt == '0));

  p_prescale_range_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    pcnt < PW'(CLKS_PER_TICK));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    cnt <= n_eff);

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    tmr_irq |-> (flag && tmr_irq_en));

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flag && tmr_irq_en) |-> tmr_irq);
endmodule

bind interval_timer interval_timer_chk #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .en(en), .start(start), .flag(flag), .tick(tick), .pcnt(pcnt), .cnt(cnt),
  .n_eff(n_eff), .tmr_irq_en(tmr_irq_en), .tmr_irq(tmr_irq)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
  localparam int CPT = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       tmr_irq_en;
  logic       tmr_irq;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  interval_timer #(.CLKS_PER_TICK(CPT)) u_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tmr_irq_en(tmr_irq_en), .tmr_irq(tmr_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  function automatic bit flag_now();
    return u_interval_timer.rd_data[7] && (addr == 3'd2);
  endfunction

  // Enable with 0->1 and count cycles until status bit 7 reads high.
  task automatic measure(input int limit, output int lat);
    wr(3'd4, 8'h01);
    addr = 3'd2;
    lat = 0;
    while (!rd_data[7] && lat < limit) begin
      @(posedge clk);
      #1 lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int lat;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0; tmr_irq_en = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(3'd3, d); check(d == 8'h01, "R1 interval", d, 1);
    rd(3'd4, d); check(d == 8'h00, "R1 ctrl", d, 0);
    rd(3'd2, d); check(d == 8'h00, "R1 status", d, 0);
    check(tmr_irq == 1'b0, "R1 irq", tmr_irq, 0);

    // R2 interval read/write
    foreach (d[i]) begin end
    for (int v = 0; v < 256; v += 51) begin
      wr(3'd3, 8'(v)); rd(3'd3, d);
      check(d == 8'(v), "R2 interval readback", d, v);
    end
    wr(3'd3, 8'h00); rd(3'd3, d); check(d == 8'h00, "R2 zero readback", d, 0);

    // R3 control: only bit 0, disabled stays idle
    wr(3'd3, 8'd2);
    wr(3'd4, 8'hFE); rd(3'd4, d); check(d == 8'h00, "R3 ctrl upper bits", d, 0);
    repeat (20) @(posedge clk);
    rd(3'd2, d); check(d == 8'h00, "R3 idle no flag", d, 0);

    // R11 unmapped offsets
    foreach (d[i]) begin end
    for (int a = 0; a < 8; a++) begin
      if (a >= 2 && a <= 4) continue;
      rd(3'(a), d); check(d == 8'h00, "R11 unmapped read", d, 0);
    end

    // R4/R5/R6/R7/R8/R9 sweep of n
    for (int n = 0; n <= 20; n++) begin
      int ne;
      ne = (n == 0) ? 1 : n;
      wr(3'd3, 8'(n));
      measure(ne * CPT + 20, lat);
      check(lat == ne * CPT, (n == 0) ? "R5 zero as one" : "R4 latency", lat, ne * CPT);
      rd(3'd2, d); check(d == 8'h80, "R6 status byte", d, 8'h80);
      tmr_irq_en = 1'b0; #1 check(tmr_irq == 1'b0, "R7 irq gated", tmr_irq, 0);
      tmr_irq_en = 1'b1; #1 check(tmr_irq == 1'b1, "R7 irq raised", tmr_irq, 1);
      repeat (3 * CPT * ne + 5) @(posedge clk);
      rd(3'd2, d); check(d == 8'h80, "R8 flag holds", d, 8'h80);
      wr(3'd4, 8'h01); rd(3'd2, d); check(d == 8'h80, "R8 re-write keeps flag", d, 8'h80);
      wr(3'd4, 8'h00); rd(3'd2, d); check(d == 8'h00, "R9 disable clears", d, 0);
      check(tmr_irq == 1'b0, "R9 irq cleared", tmr_irq, 0);
      repeat (CPT * ne + 5) @(posedge clk);
      rd(3'd2, d); check(d == 8'h00, "R9 stays clear", d, 0);
    end

    // R4 at the top of the range
    wr(3'd3, 8'd255);
    measure(255 * CPT + 20, lat);
    check(lat == 255 * CPT, "R4 latency n=255", lat, 255 * CPT);
    wr(3'd4, 8'h00);

    // R8 write enable=1 mid-count does not restart
    wr(3'd3, 8'd6);
    wr(3'd4, 8'h01);
    repeat (7) @(posedge clk);
    wr(3'd4, 8'h01);
    addr = 3'd2; lat = 8;
    while (!rd_data[7] && lat < 100) begin @(posedge clk); #1 lat++; end
    check(lat == 6 * CPT, "R8 no restart while enabled", lat, 6 * CPT);
    wr(3'd4, 8'h00);

    // R10 disable mid-interval, re-enable restarts fully
    for (int k = 1; k < 12; k += 4) begin
      wr(3'd3, 8'd5);
      wr(3'd4, 8'h01);
      repeat (k) @(posedge clk);
      wr(3'd4, 8'h00);
      measure(5 * CPT + 20, lat);
      check(lat == 5 * CPT, "R10 restart latency", lat, 5 * CPT);
      wr(3'd4, 8'h00);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule